// File: doc/BRIEF.md
# Adaptive Polynomial Corrector for a 1.5-Bit Pipeline Stage

The block rebuilds the analog input of one 1.5-bit pipeline stage in the digital domain. Each fast sample brings the stage's coarse decision (0, 1 or 2) and the residue code measured by the stages behind it. The block forms a power series in the residue code up to the fourth power. It adds a term driven by the decision and subtracts a constant offset term. All six weights come from an adaptive loop rather than from fixed radix-2 arithmetic, so a residue amplifier with gain error and a bent transfer curve can still be inverted.

A slower, accurate converter supplies reference samples now and then, each marked by a strobe. Alignment is done outside the block. A reference strobe always refers to the sample currently shown on the output. On each strobe the block takes the difference between the reference and that output and applies a least-mean-square step to every weight. The step size is a power of two chosen by a shift input. A freeze input holds the weights while correction carries on.

All numbers are signed fixed point with DW = 16 bits and FRAC = 12 fractional bits, so 4096 represents 1.0. Every product is truncated toward minus infinity by an arithmetic right shift of FRAC bits and then clamped to the 16-bit signed range [-32768, 32767].

Top module: `lms_stage_corrector`

## Requirements
- R1: While reset is held and after it is released, out_valid is 0, out_code is 0, and the weights are: alpha1 = 2048, beta = 2048, and alpha2, alpha3, alpha4 and gamma all 0.
- R2: A sample accepted on a rising edge with smp_valid high appears on the fourth rising edge, counting the accepting edge as the first. On that edge out_valid is high for one cycle. In every cycle with out_valid low, out_code keeps its value.
- R3: The decision is encoded 0, 1 or 2 on smp_dec, and it maps to a regressor (smp_dec − 1)·4096. The six regressors are p1, p2, p3, p4, that decision term, and −4096. out_code is the clamp of the sum, over the six, of each weight times its regressor shifted right by 12.
- R4: The powers are built as follows. p1 is the residue code. p2 is clamp((p1·p1)>>>12). p3 is clamp((p2·p1)>>>12). p4 is clamp((p3·p1)>>>12). A full-scale residue therefore saturates the powers and never wraps them.
- R5: On a rising edge with ref_valid high and freeze low, err = ref_val − out_code, computed at 17 bits or more. Each weight becomes clamp(w + (((err·reg)>>>12)>>>mu_shift)), where reg is the regressor held with the displayed sample. With ref_valid low, the weights do not change.
- R6: With freeze high, the weights do not change whatever ref_valid does, and corrected samples keep flowing.
- R7: When a weight update and a new output load fall on the same edge, the new output uses the weights from before the update. The update uses the previous output and its regressors.
- R8: A weight update that would leave the 16-bit signed range stops at 32767 or −32768.
- R9: coef_o packs the weights in the order alpha1 at bits [15:0], then alpha2, alpha3, alpha4, beta, and gamma at bits [95:80].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Fast sample strobe |
| smp_dec | input | 2 | Stage decision, 0/1/2 |
| smp_res | input | 16 | Residue code, signed, 12 fractional bits |
| ref_valid | input | 1 | Reference strobe for the displayed sample |
| ref_val | input | 16 | Reference value, same format |
| mu_shift | input | 4 | Step size as a right-shift amount |
| freeze | input | 1 | Hold weights when high |
| out_valid | output | 1 | New corrected code this cycle |
| out_code | output | 16 | Corrected stage input |
| coef_o | output | 96 | Six packed weights |

## Verification
The weight update and the loading of a new corrected sample can fall on the same clock edge. This happens whenever a reference strobe arrives while the fast stream is still delivering. One phase of the stimulus keeps smp_valid and ref_valid high together for hundreds of cycles, so the two collide on nearly every edge. On every cycle the bench's behavioural model decides which weights produced each output and which sample fed each update. It then compares the output code and all six weights, and it confirms that collisions actually took place.

// File: rtl/lmsc_pkg.sv
package lmsc_pkg;
    localparam int NCOEF = 6;

    typedef enum int {
        IX_A1    = 0,
        IX_A2    = 1,
        IX_A3    = 2,
        IX_A4    = 3,
        IX_BETA  = 4,
        IX_GAMMA = 5
    } coef_ix_e;

    // fixed-point product, floored by an arithmetic shift
    function automatic longint fx_mul(input longint a, input longint b, input int frac);
        return (a * b) >>> frac;
    endfunction

    // clamp to a w-bit signed range
    function automatic longint sat(input longint v, input int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction
endpackage

// File: rtl/lmsc_power_chain.sv
module lmsc_power_chain
    import lmsc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [1:0]            in_dec,
    input  logic signed [DW-1:0]  in_res,
    output logic                  o_valid,
    output logic [3:0][DW-1:0]    o_pow,
    output logic [DW-1:0]         o_dm
);
    localparam int     NST   = 3;
    localparam longint ONE_L = longint'(1) <<< FRAC;

    typedef struct packed {
        logic [NST-1:0]                v;
        logic [NST-1:0][3:0][DW-1:0]   pw;
        logic [NST-1:0][DW-1:0]        dm;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d          = chain_q;
        chain_d.v        = {chain_q.v[NST-2:0], in_valid};
        chain_d.pw[0]    = '0;
        chain_d.pw[0][0] = in_res;
        chain_d.pw[0][1] = DW'(sat(fx_mul(longint'(in_res), longint'(in_res), FRAC), DW));
        case (in_dec)
            2'd0:    chain_d.dm[0] = DW'(-ONE_L);
            2'd2:    chain_d.dm[0] = DW'(ONE_L);
            default: chain_d.dm[0] = '0;
        endcase
        for (int s = 1; s < NST; s++) begin
            chain_d.pw[s]      = chain_q.pw[s-1];
            chain_d.dm[s]      = chain_q.dm[s-1];
            chain_d.pw[s][s+1] = DW'(sat(fx_mul(longint'($signed(chain_q.pw[s-1][s])),
                                                 longint'($signed(chain_q.pw[s-1][0])), FRAC), DW));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign o_valid = chain_q.v[NST-1];
    assign o_pow   = chain_q.pw[NST-1];
    assign o_dm    = chain_q.dm[NST-1];

    // R4
    sq_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q.v[0] |-> !chain_q.pw[0][1][DW-1]);
    // R4
    p4_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> !o_pow[3][DW-1]);
endmodule

// File: rtl/lmsc_combiner.sv
module lmsc_combiner
    import lmsc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [3:0][DW-1:0]          in_pow,
    input  logic [DW-1:0]               in_dm,
    input  logic [NCOEF-1:0][DW-1:0]    coef,
    output logic                        out_valid,
    output logic [DW-1:0]               out_code,
    output logic [NCOEF-1:0][DW-1:0]    rg_held
);
    localparam longint ONE_L = longint'(1) <<< FRAC;

    typedef struct packed {
        logic                       v;
        logic [DW-1:0]              y;
        logic [NCOEF-1:0][DW-1:0]   rg;
    } comb_t;

    comb_t comb_d, comb_q;
    logic [NCOEF-1:0][DW-1:0] rg_in;
    longint acc;

    always_comb begin
        rg_in[IX_A1]    = in_pow[0];
        rg_in[IX_A2]    = in_pow[1];
        rg_in[IX_A3]    = in_pow[2];
        rg_in[IX_A4]    = in_pow[3];
        rg_in[IX_BETA]  = in_dm;
        rg_in[IX_GAMMA] = DW'(-ONE_L);
        acc = 0;
        for (int k = 0; k < NCOEF; k++) begin
            acc = acc + fx_mul(longint'($signed(coef[k])), longint'($signed(rg_in[k])), FRAC);
        end
        comb_d   = comb_q;
        comb_d.v = in_valid;
        if (in_valid) begin
            comb_d.y  = DW'(sat(acc, DW));
            comb_d.rg = rg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) comb_q <= '0;
        else        comb_q <= comb_d;
    end

    assign out_valid = comb_q.v;
    assign out_code  = comb_q.y;
    assign rg_held   = comb_q.rg;

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));
    // R2
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_code));
endmodule

// File: rtl/lmsc_coef_update.sv
module lmsc_coef_update
    import lmsc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 12,
    parameter int SHW  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ref_valid,
    input  logic [DW-1:0]               ref_val,
    input  logic [SHW-1:0]              mu_shift,
    input  logic                        freeze,
    input  logic [DW-1:0]               y_shown,
    input  logic [NCOEF-1:0][DW-1:0]    rg_shown,
    output logic [NCOEF-1:0][DW-1:0]    coef
);
    localparam longint HALF_L = longint'(1) <<< (FRAC - 1);

    typedef struct packed {
        logic [NCOEF-1:0][DW-1:0] c;
    } wt_t;

    wt_t wt_d, wt_q;
    longint err;

    always_comb begin
        err  = longint'($signed(ref_val)) - longint'($signed(y_shown));
        wt_d = wt_q;
        if (ref_valid && !freeze) begin
            for (int k = 0; k < NCOEF; k++) begin
                wt_d.c[k] = DW'(sat(longint'($signed(wt_q.c[k])) +
                    (fx_mul(err, longint'($signed(rg_shown[k])), FRAC) >>> mu_shift), DW));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wt_q            <= '0;
            wt_q.c[IX_A1]   <= DW'(HALF_L);
            wt_q.c[IX_BETA] <= DW'(HALF_L);
        end else begin
            wt_q <= wt_d;
        end
    end

    assign coef = wt_q.c;

    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(coef));
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |=> $stable(coef));
endmodule

// File: rtl/lms_stage_corrector.sv
module lms_stage_corrector
    import lmsc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 12,
    parameter int SHW  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic [1:0]            smp_dec,
    input  logic [DW-1:0]         smp_res,
    input  logic                  ref_valid,
    input  logic [DW-1:0]         ref_val,
    input  logic [SHW-1:0]        mu_shift,
    input  logic                  freeze,
    output logic                  out_valid,
    output logic [DW-1:0]         out_code,
    output logic [NCOEF*DW-1:0]   coef_o
);
    logic                      pc_valid;
    logic [3:0][DW-1:0]        pc_pow;
    logic [DW-1:0]             pc_dm;
    logic [NCOEF-1:0][DW-1:0]  coef_w;
    logic [NCOEF-1:0][DW-1:0]  rg_w;

    lmsc_power_chain #(.DW(DW), .FRAC(FRAC)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (smp_valid),
        .in_dec   (smp_dec),
        .in_res   ($signed(smp_res)),
        .o_valid  (pc_valid),
        .o_pow    (pc_pow),
        .o_dm     (pc_dm)
    );

    lmsc_combiner #(.DW(DW), .FRAC(FRAC)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pc_valid),
        .in_pow    (pc_pow),
        .in_dm     (pc_dm),
        .coef      (coef_w),
        .out_valid (out_valid),
        .out_code  (out_code),
        .rg_held   (rg_w)
    );

    lmsc_coef_update #(.DW(DW), .FRAC(FRAC), .SHW(SHW)) u_upd (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_valid (ref_valid),
        .ref_val   (ref_val),
        .mu_shift  (mu_shift),
        .freeze    (freeze),
        .y_shown   (out_code),
        .rg_shown  (rg_w),
        .coef      (coef_w)
    );

    assign coef_o = coef_w;
endmodule

// File: tb/lms_stage_corrector_bench.sv
`timescale 1ns/1ps
module lms_stage_corrector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [1:0]  smp_dec = 2'd1;
    logic [15:0] smp_res = '0;
    logic        ref_valid = 1'b0;
    logic [15:0] ref_val = '0;
    logic [3:0]  mu_shift = 4'd4;
    logic        freeze = 1'b0;
    logic        out_valid;
    logic [15:0] out_code;
    logic [95:0] coef_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    bit live_cmp = 0;
    bit rail_seen = 0;
    int collisions = 0;
    string coef_tag = "R5";

    always #5 clk = ~clk;

    lms_stage_corrector u_lms_stage_corrector (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_dec(smp_dec),
        .smp_res(smp_res), .ref_valid(ref_valid), .ref_val(ref_val),
        .mu_shift(mu_shift), .freeze(freeze), .out_valid(out_valid),
        .out_code(out_code), .coef_o(coef_o)
    );

    function automatic longint s16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint fm(longint a, longint b);
        return (a * b) >>> 12;
    endfunction

    function automatic longint plant(longint r, longint d);
        longint p2, p3;
        p2 = fm(r, r);
        p3 = fm(p2, r);
        return s16(fm(r, 2150) + fm((d - 1) * 4096, 1990) + fm(p2, 300) + fm(p3, -150) - 37);
    endfunction

    function automatic longint dut_coef(int k);
        return longint'($signed(coef_o[k*16 +: 16]));
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural model
    typedef struct { bit v; longint d; longint r; } smp_t;
    smp_t   pipe[$];
    longint m_c[6];
    longint m_rg[6];
    longint m_y = 0;
    bit     m_v = 0;
    longint m_truth = 0;

    always @(posedge clk) begin : model
        smp_t   s;
        longint nc[6];
        longint rg[6];
        longint acc;
        longint err;
        if (!rst_n) begin
            pipe.delete();
            for (int i = 0; i < 3; i++) pipe.push_back('{0, 1, 0});
            m_c = '{2048, 0, 0, 0, 2048, 0};
            m_rg = '{0, 0, 0, 0, 0, 0};
            m_y = 0; m_v = 0; m_truth = 0;
        end else begin
            pipe.push_back('{smp_valid, longint'(smp_dec), longint'($signed(smp_res))});
            s = pipe.pop_front();
            nc = m_c;
            if (ref_valid && !freeze) begin
                err = longint'($signed(ref_val)) - m_y;
                for (int k = 0; k < 6; k++) nc[k] = s16(m_c[k] + (fm(err, m_rg[k]) >>> mu_shift));
                if (s.v) collisions++;
            end
            if (s.v) begin
                rg[0] = s.r;
                rg[1] = s16(fm(s.r, s.r));
                rg[2] = s16(fm(rg[1], s.r));
                rg[3] = s16(fm(rg[2], s.r));
                rg[4] = (s.d - 1) * 4096;
                rg[5] = -4096;
                acc = 0;
                for (int k = 0; k < 6; k++) acc += fm(m_c[k], rg[k]);
                m_y = s16(acc);
                m_rg = rg;
                m_truth = plant(s.r, s.d);
                m_v = 1;
            end else begin
                m_v = 0;
            end
            m_c = nc;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && live_cmp) begin
            chk("R2 out_valid", longint'(out_valid), longint'(m_v));
            if (m_v) chk("R3 out_code", longint'($signed(out_code)), m_y);
            for (int k = 0; k < 6; k++) begin
                chk({coef_tag, " R9 weight"}, dut_coef(k), m_c[k]);
                if (dut_coef(k) == 32767 || dut_coef(k) == -32768) rail_seen = 1;
            end
        end
    end

    task automatic drive(bit v, int d, int r, bit rv, int rval);
        @(negedge clk);
        smp_valid = v;
        smp_dec   = 2'(d);
        smp_res   = 16'(r);
        ref_valid = rv;
        ref_val   = 16'(rval);
    endtask

    task automatic one_sample(int d, int r, longint exp_y);
        drive(1, d, r, 1, 5000);
        for (int i = 0; i < 3; i++) drive(0, 1, 0, 1, 5000);
        @(negedge clk); #1;
        chk("R2 latency valid", longint'(out_valid), 1);
        chk("R3 directed code", longint'($signed(out_code)), exp_y);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R1: reset values while held
        chk("R1 valid in reset", longint'(out_valid), 0);
        chk("R1 code in reset", longint'($signed(out_code)), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 valid", longint'(out_valid), 0);
        chk("R1 alpha1", dut_coef(0), 2048);
        chk("R1 beta", dut_coef(4), 2048);
        chk("R1 alpha2", dut_coef(1), 0);
        chk("R1 gamma", dut_coef(5), 0);
        live_cmp = 1;

        // R6: frozen weights, correction still runs (R3 directed values)
        freeze = 1'b1;
        coef_tag = "R6";
        one_sample(1, 2048, 1024);
        one_sample(2, 0, 2048);
        one_sample(0, -4096, -4096);
        chk("R6 alpha1 frozen", dut_coef(0), 2048);
        chk("R6 beta frozen", dut_coef(4), 2048);
        chk("R6 gamma frozen", dut_coef(5), 0);

        // R5: training with a sparse reference
        freeze = 1'b0;
        mu_shift = 4'd4;
        coef_tag = "R5";
        for (int i = 0; i < 2000; i++) begin
            drive(($urandom_range(0, 9) < 7), $urandom_range(0, 2),
                  int'($urandom_range(0, 6000)) - 3000, (i % 5 == 4), int'(m_truth));
        end

        // R7: reference and stream on every edge
        coef_tag = "R7";
        mu_shift = 4'd6;
        for (int i = 0; i < 300; i++) begin
            drive(1, $urandom_range(0, 2), int'($urandom_range(0, 6000)) - 3000, 1, int'(m_truth));
        end
        chk("R7 collisions seen", longint'(collisions > 100), 1);

        // R4: full-scale residues saturate the powers
        coef_tag = "R4";
        freeze = 1'b1;
        for (int i = 0; i < 40; i++) begin
            int rr;
            rr = (i % 4 == 0) ? 32767 : (i % 4 == 1) ? -32768 : (i % 4 == 2) ? 20000 : -15000;
            drive(1, i % 3, rr, 0, 0);
        end
        for (int i = 0; i < 5; i++) drive(0, 1, 0, 0, 0);

        // R8: large error with no step attenuation drives weights to the rails
        coef_tag = "R8";
        freeze = 1'b0;
        mu_shift = 4'd0;
        for (int i = 0; i < 6; i++) drive(1, 2, 32767, 0, 0);
        for (int i = 0; i < 30; i++) drive(1, 2, 32767, 1, -32768);
        for (int i = 0; i < 6; i++) drive(0, 1, 0, 0, 0);
        chk("R8 weight reached rail", longint'(rail_seen), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule